// File: doc/BRIEF.md
# Feed-Forward Phase Correction Engine

This block runs the real-time side of a pulsed feed-forward phase loop for one klystron channel. A chip instantiates it twice, one copy per klystron, and both copies run on the same clocks. While the pulse trigger is high, every IF-rate clock brings a reference phase, a measured phase and the measured I/Q pair. The engine subtracts the measured phase from the reference. It then adds a correction word, read from a table at the current sample position within the pulse, and passes the corrected phase on to the vector regeneration stage. Phase words are binary angles, so the sum wraps modulo one full turn.

Each pulse's I/Q samples are also logged into a capture FIFO. When the pulse ends, a sticky interrupt tells the host to drain the FIFO. The host then rewrites correction words through a separate write port on the table, between pulses. If a pulse starts before the FIFO has been emptied, an overflow flag is set. An open-loop input zeroes the correction term and leaves capture running.

A final stage runs on a clock at twice the IF rate and turns the regenerated parallel I/Q pair into one interleaved word stream for a DAC. This stage assumes that reset is released so that the first fast edge after release coincides with an IF-clock rising edge.

Top module: `ff_phase_engine`

## Requirements
- R1: While trig_i is high in a clk_i cycle, exactly two clk_i cycles later phase_vld_o is 1 and phase_o equals (ref_phase_i - meas_phase_i + table[idx]) modulo 2^PW. In every other cycle phase_vld_o is 0.
- R2: The table index idx is 0 in the first cycle that trig_i is high after a low cycle. It increases by one in each further high cycle and stops at TBL_DEPTH-1, so samples beyond the table length all use the last word.
- R3: With open_loop_i high in a sample cycle, that sample's phase_o equals ref_phase_i - meas_phase_i modulo 2^PW. Capture of the sample into the FIFO is unchanged.
- R4: When tbl_we_i is high in a clk_i cycle, tbl_wdata_i is stored at tbl_addr_i. Samples of later pulses that read that index use the new word.
- R5: Each cycle with trig_i high pushes {meas_i_i, meas_q_i} into the FIFO in arrival order, unless the FIFO already holds CAP_DEPTH entries, in which case the sample is dropped. The oldest entry is always shown on fifo_i_o and fifo_q_o. fifo_rd_i removes that entry at the clock edge. fifo_empty_o is 1 exactly when no entry is held.
- R6: irq_o becomes 1 after the edge that samples the first low trig_i following a high one. It stays 1 until an edge that samples stat_clr_i high. If a pulse end and a clear fall in the same cycle, the pulse end wins.
- R7: ovf_o becomes 1 after the edge at which a pulse starts while the FIFO holds at least one entry. It stays 1 until stat_clr_i clears it, and the set condition wins over the clear.
- R8: On clk2x_i, dac_o alternates between two words. After the fast edge aligned with a clk_i rising edge, it carries regen_i_i as sampled at that edge with dac_q_sel_o 0. After the next fast edge it carries the matching regen_q_i with dac_q_sel_o 1. This adds one IF period of latency.
- R9: After reset, phase_vld_o, irq_o and ovf_o are 0 and fifo_empty_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | IF-rate clock |
| clk2x_i | input | 1 | Clock at twice the IF rate, edge-aligned with clk_i, used by the interleaver |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | High for the duration of the RF pulse |
| open_loop_i | input | 1 | Forces the correction term to zero |
| ref_phase_i | input | PW | Reference phase as a binary angle |
| meas_phase_i | input | PW | Measured phase as a binary angle |
| meas_i_i | input | DW | Measured in-phase sample for capture |
| meas_q_i | input | DW | Measured quadrature sample for capture |
| tbl_we_i | input | 1 | Host write strobe for the correction table |
| tbl_addr_i | input | log2(TBL_DEPTH) | Host write index |
| tbl_wdata_i | input | PW | Host correction word |
| fifo_rd_i | input | 1 | Host pop of the capture FIFO |
| stat_clr_i | input | 1 | Clears the interrupt and overflow flags |
| regen_i_i | input | DW | Regenerated in-phase word for the DAC |
| regen_q_i | input | DW | Regenerated quadrature word for the DAC |
| phase_o | output | PW | Corrected phase |
| phase_vld_o | output | 1 | phase_o holds a sample |
| fifo_i_o | output | DW | Oldest captured in-phase word |
| fifo_q_o | output | DW | Oldest captured quadrature word |
| fifo_empty_o | output | 1 | Capture FIFO holds no entry |
| irq_o | output | 1 | End-of-pulse interrupt, sticky |
| ovf_o | output | 1 | A pulse started before the FIFO was drained, sticky |
| dac_o | output | DW | Interleaved I/Q stream |
| dac_q_sel_o | output | 1 | 1 when dac_o carries the quadrature word |

## Verification
The in-RTL assertions check properties that must hold on every cycle. They cover the two-cycle alignment of phase_vld_o with the trigger, the unit step of the table index inside a pulse, the FIFO occupancy bound, the stickiness of the interrupt and overflow flags, and the rule that a quadrature word on the DAC is always followed by an in-phase word. The bench's scenarios are the only way to show the data values: the modulo sum against a mirrored table, index saturation in a pulse longer than the table, the effect of a host rewrite and of open-loop mode, the capture order and the drops when the FIFO is full, an overflow caused by a second pulse before the FIFO is drained, and the word order on the interleaved stream.

// File: rtl/ffpe_pkg.sv
package ffpe_pkg;
  function automatic int unsigned idx_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ffpe_pulse_edge.sv
module ffpe_pulse_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o,
  output logic fall_o
);
  logic trig_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_d <= 1'b0;
    else         trig_d <= trig_i;
  end

  assign rise_o = trig_i & ~trig_d;
  assign fall_o = ~trig_i & trig_d;
endmodule

// File: rtl/ffpe_corr_table.sv
module ffpe_corr_table #(
  parameter int unsigned PW    = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = ffpe_pkg::idx_w(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [PW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [PW-1:0] wr_data_i
);
  logic [PW-1:0] mem [DEPTH];

  // host write port
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  // synchronous read port, aligned with the error stage
  always_ff @(posedge clk_i) begin
    rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/ffpe_phase_path.sv
module ffpe_phase_path #(
  parameter int unsigned PW    = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = ffpe_pkg::idx_w(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          rise_i,
  input  logic          open_loop_i,
  input  logic [PW-1:0] ref_phase_i,
  input  logic [PW-1:0] meas_phase_i,
  input  logic          tbl_we_i,
  input  logic [AW-1:0] tbl_addr_i,
  input  logic [PW-1:0] tbl_wdata_i,
  output logic [PW-1:0] phase_o,
  output logic          phase_vld_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q, rd_addr;
  logic [PW-1:0] ff_word, err_q, phase_q;
  logic          ol_q, v1_q, v2_q;

  assign rd_addr = rise_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (act_i) cnt_q <= (rd_addr == LAST) ? LAST : rd_addr + 1'b1;
  end

  ffpe_corr_table #(.PW(PW), .DEPTH(DEPTH)) u_table (
    .clk_i     (clk_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (ff_word),
    .wr_en_i   (tbl_we_i),
    .wr_addr_i (tbl_addr_i),
    .wr_data_i (tbl_wdata_i)
  );

  // stage 1: error, stage 2: add correction (binary angle wraps)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      ol_q    <= 1'b0;
      v1_q    <= 1'b0;
      phase_q <= '0;
      v2_q    <= 1'b0;
    end else begin
      err_q   <= ref_phase_i - meas_phase_i;
      ol_q    <= open_loop_i;
      v1_q    <= act_i;
      phase_q <= err_q + (ol_q ? '0 : ff_word);
      v2_q    <= v1_q;
    end
  end

  assign phase_o     = phase_q;
  assign phase_vld_o = v2_q;

  AST_PHASE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_vld_o |-> $past(act_i, 2)); // R1

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !rise_i && $past(act_i) && $past(rd_addr) != LAST)
      |-> rd_addr == AW'($past(rd_addr) + 1'b1)); // R2
endmodule

// File: rtl/ffpe_capture.sv
module ffpe_capture #(
  parameter int unsigned DW    = 14,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = ffpe_pkg::idx_w(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [DW-1:0] i_i,
  input  logic [DW-1:0] q_i,
  input  logic          rd_i,
  input  logic          clr_i,
  output logic [DW-1:0] i_o,
  output logic [DW-1:0] q_o,
  output logic          empty_o,
  output logic          irq_o,
  output logic          ovf_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [2*DW-1:0] mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt_q;
  logic            push, pop, full, irq_q, ovf_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign push  = act_i && !full;
  assign pop   = rd_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (push) mem[wr_ptr] <= {i_i, q_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // sticky flags, set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (fall_i)     irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
      if (rise_i && cnt_q != '0) ovf_q <= 1'b1;
      else if (clr_i)            ovf_q <= 1'b0;
    end
  end

  assign {i_o, q_o} = mem[rd_ptr];
  assign empty_o    = (cnt_q == '0);
  assign irq_o      = irq_q;
  assign ovf_o      = ovf_q;

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q); // R6

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q); // R7
endmodule

// File: rtl/ffpe_interleave.sv
module ffpe_interleave #(
  parameter int unsigned DW = 14
) (
  input  logic          clk2x_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] i_i,
  input  logic [DW-1:0] q_i,
  output logic [DW-1:0] dac_o,
  output logic          q_sel_o
);
  logic          slot_q, osel_q;
  logic [DW-1:0] q_hold, dac_q;

  // slot 0 lines up with the IF clock edge after reset release
  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 1'b0;
      osel_q <= 1'b0;
      q_hold <= '0;
      dac_q  <= '0;
    end else begin
      slot_q <= ~slot_q;
      if (!slot_q) begin
        dac_q  <= i_i;
        q_hold <= q_i;
        osel_q <= 1'b0;
      end else begin
        dac_q  <= q_hold;
        osel_q <= 1'b1;
      end
    end
  end

  assign dac_o   = dac_q;
  assign q_sel_o = osel_q;

  AST_Q_THEN_I: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    q_sel_o |=> !q_sel_o); // R8
endmodule

// File: rtl/ff_phase_engine.sv
module ff_phase_engine #(
  parameter int unsigned PW        = 16,
  parameter int unsigned DW        = 14,
  parameter int unsigned TBL_DEPTH = 64,
  parameter int unsigned CAP_DEPTH = 64
) (
  input  logic                                    clk_i,
  input  logic                                    clk2x_i,
  input  logic                                    rst_ni,
  input  logic                                    trig_i,
  input  logic                                    open_loop_i,
  input  logic [PW-1:0]                           ref_phase_i,
  input  logic [PW-1:0]                           meas_phase_i,
  input  logic [DW-1:0]                           meas_i_i,
  input  logic [DW-1:0]                           meas_q_i,
  input  logic                                    tbl_we_i,
  input  logic [ffpe_pkg::idx_w(TBL_DEPTH)-1:0]   tbl_addr_i,
  input  logic [PW-1:0]                           tbl_wdata_i,
  input  logic                                    fifo_rd_i,
  input  logic                                    stat_clr_i,
  input  logic [DW-1:0]                           regen_i_i,
  input  logic [DW-1:0]                           regen_q_i,
  output logic [PW-1:0]                           phase_o,
  output logic                                    phase_vld_o,
  output logic [DW-1:0]                           fifo_i_o,
  output logic [DW-1:0]                           fifo_q_o,
  output logic                                    fifo_empty_o,
  output logic                                    irq_o,
  output logic                                    ovf_o,
  output logic [DW-1:0]                           dac_o,
  output logic                                    dac_q_sel_o
);
  logic rise, fall;

  ffpe_pulse_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  ffpe_phase_path #(.PW(PW), .DEPTH(TBL_DEPTH)) u_path (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .act_i        (trig_i),
    .rise_i       (rise),
    .open_loop_i  (open_loop_i),
    .ref_phase_i  (ref_phase_i),
    .meas_phase_i (meas_phase_i),
    .tbl_we_i     (tbl_we_i),
    .tbl_addr_i   (tbl_addr_i),
    .tbl_wdata_i  (tbl_wdata_i),
    .phase_o      (phase_o),
    .phase_vld_o  (phase_vld_o)
  );

  ffpe_capture #(.DW(DW), .DEPTH(CAP_DEPTH)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (trig_i),
    .rise_i  (rise),
    .fall_i  (fall),
    .i_i     (meas_i_i),
    .q_i     (meas_q_i),
    .rd_i    (fifo_rd_i),
    .clr_i   (stat_clr_i),
    .i_o     (fifo_i_o),
    .q_o     (fifo_q_o),
    .empty_o (fifo_empty_o),
    .irq_o   (irq_o),
    .ovf_o   (ovf_o)
  );

  ffpe_interleave #(.DW(DW)) u_ilv (
    .clk2x_i (clk2x_i),
    .rst_ni  (rst_ni),
    .i_i     (regen_i_i),
    .q_i     (regen_q_i),
    .dac_o   (dac_o),
    .q_sel_o (dac_q_sel_o)
  );
endmodule

// File: tb/ff_phase_engine_test.sv
`timescale 1ns/100ps
module ff_phase_engine_test;
  localparam int PW = 16, DW = 14, TD = 64, CD = 64, TAW = 6;

  logic clk_i = 1'b0, clk2x_i = 1'b1, rst_ni = 1'b0;
  logic trig_i = 0, open_loop_i = 0, tbl_we_i = 0, fifo_rd_i = 0, stat_clr_i = 0;
  logic [PW-1:0] ref_phase_i = '0, meas_phase_i = '0, tbl_wdata_i = '0;
  logic [DW-1:0] meas_i_i = '0, meas_q_i = '0, regen_i_i = '0, regen_q_i = '0;
  logic [TAW-1:0] tbl_addr_i = '0;
  logic [PW-1:0] phase_o;
  logic phase_vld_o, fifo_empty_o, irq_o, ovf_o, dac_q_sel_o;
  logic [DW-1:0] fifo_i_o, fifo_q_o, dac_o;

  always #5 clk_i = ~clk_i;
  always #2.5 clk2x_i = ~clk2x_i;

  ff_phase_engine #(.PW(PW), .DW(DW), .TBL_DEPTH(TD), .CAP_DEPTH(CD)) uut (.*);

  int checks = 0, errors = 0;
  logic [PW-1:0] tbl [TD];
  logic [2*DW-1:0] capq [$];
  bit m_trig = 0, m_irq = 0, m_ovf = 0;
  int m_idx = 0;
  bit p_v = 0;
  logic [PW-1:0] p_p = '0;
  string p_tag = "R1", ptag = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cycle(input bit trig, input bit ol, input bit rd, input bit clr,
                       input bit we, input logic [TAW-1:0] wa, input logic [PW-1:0] wd);
    logic [PW-1:0] r, m, cur_p;
    logic [DW-1:0] si, sq;
    bit rise, fall, cur_v;
    string cur_tag;
    r = PW'($urandom); m = PW'($urandom); si = DW'($urandom); sq = DW'($urandom);
    trig_i = trig; open_loop_i = ol; fifo_rd_i = rd; stat_clr_i = clr;
    tbl_we_i = we; tbl_addr_i = wa; tbl_wdata_i = wd;
    ref_phase_i = r; meas_phase_i = m; meas_i_i = si; meas_q_i = sq;
    rise = trig && !m_trig;
    fall = !trig && m_trig;
    if (trig) m_idx = rise ? 0 : ((m_idx == TD-1) ? m_idx : m_idx + 1);
    cur_v = trig;
    cur_p = r - m + (ol ? '0 : tbl[m_idx]);
    cur_tag = ol ? "R3 open-loop phase" : (m_idx == TD-1) ? "R2 saturated-index phase" : ptag;
    if (rise && capq.size() != 0) m_ovf = 1; else if (clr) m_ovf = 0;
    if (fall) m_irq = 1; else if (clr) m_irq = 0;
    if (rd && capq.size() > 0) void'(capq.pop_front());
    if (trig && capq.size() < CD) capq.push_back({si, sq});
    if (we) tbl[wa] = wd;
    m_trig = trig;
    @(posedge clk_i); #2;
    chk("R1 phase_vld", 32'(phase_vld_o), 32'(p_v));
    if (p_v) chk(p_tag, 32'(phase_o), 32'(p_p));
    chk("R6 irq", 32'(irq_o), 32'(m_irq));
    chk("R7 ovf", 32'(ovf_o), 32'(m_ovf));
    chk("R5 empty", 32'(fifo_empty_o), 32'(capq.size() == 0));
    p_v = cur_v; p_p = cur_p; p_tag = cur_tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle(0, 0, 0, 0, 0, '0, '0);
  endtask

  task automatic pulse(input int len, input bit ol);
    for (int k = 0; k < len; k++) cycle(1, ol, 0, 0, 0, '0, '0);
    cycle(0, 0, 0, 0, 0, '0, '0);
  endtask

  task automatic drain();
    while (capq.size() > 0) begin
      chk("R5 fifo head I", 32'(fifo_i_o), 32'(capq[0][2*DW-1:DW]));
      chk("R5 fifo head Q", 32'(fifo_q_o), 32'(capq[0][DW-1:0]));
      cycle(0, 0, 1, 0, 0, '0, '0);
    end
    chk("R5 drained", 32'(fifo_empty_o), 32'd1);
  endtask

  task automatic rewrite(input int n);
    for (int k = 0; k < n; k++)
      cycle(0, 0, 0, 0, 1, TAW'($urandom), PW'($urandom));
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1 rst_ni = 1'b1;
    @(posedge clk_i); #2;
    // R9 reset state
    chk("R9 vld", 32'(phase_vld_o), 32'd0);
    chk("R9 irq", 32'(irq_o), 32'd0);
    chk("R9 ovf", 32'(ovf_o), 32'd0);
    chk("R9 empty", 32'(fifo_empty_o), 32'd1);
    // fill the table through the host port (R4)
    for (int a = 0; a < TD; a++) cycle(0, 0, 0, 0, 1, TAW'(a), PW'($urandom));
    idle(2);
    pulse(12, 0);                       // R1
    idle(2);
    pulse(20, 0);                       // R7: starts with 12 entries pending
    drain();
    cycle(0, 0, 0, 1, 0, '0, '0);       // clear R6/R7 flags
    ptag = "R4 phase after rewrite";
    rewrite(8);
    pulse(25, 0);                       // R4
    drain();
    pulse(18, 1);                       // R3 open loop, capture still on
    cycle(0, 0, 0, 1, 0, '0, '0);
    drain();
    ptag = "R1 phase";
    pulse(70, 0);                       // R2 saturation, R5 full drops
    chk("R5 full count", 32'(capq.size()), 32'(CD));
    drain();
    // R6 set beats clear: clear in the pulse-end cycle
    for (int k = 0; k < 6; k++) cycle(1, 0, 0, 0, 0, '0, '0);
    cycle(0, 0, 0, 1, 0, '0, '0);
    chk("R6 set wins", 32'(irq_o), 32'd1);
    drain();
    cycle(0, 0, 0, 1, 0, '0, '0);
    for (int n = 0; n < 4; n++) begin
      rewrite(4);
      pulse(3 + int'($urandom % 38), bit'($urandom % 2));
      if (n % 2 == 1) drain();
    end
    drain();
    idle(3);
    // R8 interleaver
    for (int k = 0; k < 16; k++) begin
      logic [DW-1:0] ei, eq;
      ei = DW'($urandom); eq = DW'($urandom);
      regen_i_i = ei; regen_q_i = eq;
      @(posedge clk_i); #2;
      chk("R8 dac I", 32'(dac_o), 32'(ei));
      chk("R8 sel I", 32'(dac_q_sel_o), 32'd0);
      #5;
      chk("R8 dac Q", 32'(dac_o), 32'(eq));
      chk("R8 sel Q", 32'(dac_q_sel_o), 32'd1);
    end
    summary();
  end
endmodule